// File: doc/BRIEF.md
# Filtered Timer Input Edge Detector

This block turns an asynchronous timer input pin into clean, single-cycle edge events for a timer. The pin first passes through a multi-flop synchronizer. A sampling filter then looks at the synchronized level only on sampling ticks and adopts a new level once that level has been seen on consecutive ticks, so short spikes never reach the timer.

The tick that drives the filter depends on the role of the edge. When the edge clocks the counter, the filter runs on a half-system-rate tick. When the edge is a capture trigger, it runs on the selected count-clock tick. A parent block supplies both ticks and a role select.

A 2-bit select picks which edges count as valid: rising, falling, both, or none. A timer-enable input gates event generation. The first enable after reset reports a rising edge at once if the filtered pin is already high. Any later enable, after the timer has run and been stopped, produces no event of its own.

Top module: `timer_pin_edge_filter`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it is released, `rise_evt`, `fall_evt` and `valid_evt` are all low.
- R2: With `clk_role` = 1, the filter samples only on cycles where `half_tick` is high. A pin level held for two consecutive `half_tick` samples (4 system cycles when `half_tick` alternates) is accepted.
- R3: A pin pulse that is seen on only one sampling tick is discarded and produces no event.
- R4: With `clk_role` = 0, the filter samples only on cycles where `cnt_tick` is high. A pulse covering one count tick is discarded, and a pulse lasting longer than two count-tick periods is accepted.
- R5: `edge_sel` is encoded as 2'b00 rising, 2'b01 falling, 2'b10 both, 2'b11 none. `valid_evt` pulses for an accepted edge of a selected kind only. `rise_evt` and `fall_evt` report every accepted edge regardless of `edge_sel`.
- R6: On the first enable after reset, if the filtered level is already high, `rise_evt` pulses in the cycle after `tmr_en` is first sampled high. `valid_evt` pulses with it when rising or both edges are selected.
- R7: Enabling the timer again after it has been stopped produces no event, even if the pin level changed while the timer was stopped.
- R8: No event is produced in a cycle that follows a cycle where `tmr_en` was low.
- R9: Each event output is high for exactly one system clock cycle per accepted edge, and `rise_evt` and `fall_evt` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_async | input | 1 | Raw asynchronous timer input pin |
| tmr_en | input | 1 | Timer run enable |
| clk_role | input | 1 | 1: edge clocks the counter (half-rate tick); 0: edge is a capture trigger (count tick) |
| half_tick | input | 1 | Half-system-rate sampling enable |
| cnt_tick | input | 1 | Selected count-clock sampling enable |
| edge_sel | input | 2 | Valid edge select (00 rise, 01 fall, 10 both, 11 none) |
| rise_evt | output | 1 | One-cycle pulse on an accepted rising edge |
| fall_evt | output | 1 | One-cycle pulse on an accepted falling edge |
| valid_evt | output | 1 | One-cycle pulse on an accepted edge that matches `edge_sel` |

## Verification
The bench uses the default parameters: two synchronizer stages and a two-sample filter. It drives `half_tick` alternating every cycle and `cnt_tick` once every four cycles. With these values, pulse widths of two, four and twelve cycles fall exactly on the one-sample and two-sample boundaries of each sampling role, so acceptance and rejection are fully determined. Holding the pin high through reset makes the first-enable rising edge reachable. Toggling the pin while the timer is stopped exercises the silent re-enable path.

// File: rtl/tpef_pkg.sv
// Package: shared types for the filtered timer pin edge detector.
// Assumes: nothing beyond IEEE 1800-2017.
package tpef_pkg;

    // Valid edge selection encoding seen on the edge_sel port.
    typedef enum logic [1:0] {
        SEL_RISE = 2'b00,
        SEL_FALL = 2'b01,
        SEL_BOTH = 2'b10,
        SEL_NONE = 2'b11
    } edge_sel_e;

endpackage

// File: rtl/tpef_sync.sv
// Module: tpef_sync
// Brings an asynchronous pin into the clk domain through a flop chain.
// Assumes: STAGES >= 2; reset value of the chain is low.
module tpef_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);

    logic [STAGES-1:0] chain;

    // Shift the pin through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], d_async};
        end
    end

    assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/tpef_filter.sv
// Module: tpef_filter
// Samples the synchronized level on a tick chosen by the edge role and
// adopts a new level once SAMPLES consecutive samples agree on it.
// Assumes: SAMPLES >= 2; filtered level resets low.
module tpef_filter #(
    parameter int SAMPLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_in,
    input  logic clk_role,
    input  logic half_tick,
    input  logic cnt_tick,
    output logic tick_sel,
    output logic lvl_out
);

    localparam int HIST_W = SAMPLES - 1;

    logic [HIST_W-1:0] hist;
    logic [SAMPLES-1:0] window;
    logic all_hi;
    logic all_lo;

    // Choose the sampling tick from the role of the edge.
    always_comb begin
        tick_sel = clk_role ? half_tick : cnt_tick;
    end

    // Form the window of previous samples plus the current one.
    always_comb begin
        window = {hist, lvl_in};
        all_hi = &window;
        all_lo = ~(|window);
    end

    // Record samples and update the accepted level on agreement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist    <= '0;
            lvl_out <= 1'b0;
        end else if (tick_sel) begin
            hist <= window[HIST_W-1:0];
            if (all_hi) begin
                lvl_out <= 1'b1;
            end else if (all_lo) begin
                lvl_out <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/tpef_edge.sv
// Module: tpef_edge
// Compares the filtered level with a reference level and produces
// registered one-cycle edge pulses while the timer is enabled.
// Assumes: reference resets low, so a high level at the very first enable
// reads as a rising edge; after the first enable the reference follows the
// level even while stopped, so re-enabling is silent.
module tpef_edge
    import tpef_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      lvl,
    input  logic      tmr_en,
    input  edge_sel_e sel,
    output logic      rise_evt,
    output logic      fall_evt,
    output logic      valid_evt
);

    logic ref_lvl;
    logic seen_en;
    logic rise_c;
    logic fall_c;
    logic valid_c;

    // Detect level differences, gated by the enable.
    always_comb begin
        rise_c = tmr_en &  lvl & ~ref_lvl;
        fall_c = tmr_en & ~lvl &  ref_lvl;
    end

    // Apply the edge selection to the raw edge events.
    always_comb begin
        unique case (sel)
            SEL_RISE: valid_c = rise_c;
            SEL_FALL: valid_c = fall_c;
            SEL_BOTH: valid_c = rise_c | fall_c;
            default:  valid_c = 1'b0;
        endcase
    end

    // Track whether the timer has ever been enabled since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_en <= 1'b0;
        end else if (tmr_en) begin
            seen_en <= 1'b1;
        end
    end

    // Reference level follows the filtered level once armed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_lvl <= 1'b0;
        end else if (tmr_en || seen_en) begin
            ref_lvl <= lvl;
        end
    end

    // Register the event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_evt  <= 1'b0;
            fall_evt  <= 1'b0;
            valid_evt <= 1'b0;
        end else begin
            rise_evt  <= rise_c;
            fall_evt  <= fall_c;
            valid_evt <= valid_c;
        end
    end

endmodule

// File: rtl/timer_pin_edge_filter.sv
// Module: timer_pin_edge_filter (top)
// Synchronizes and noise-filters a timer input pin, then reports rising,
// falling and selected edges as one-cycle pulses.
// Assumes: half_tick and cnt_tick are single-cycle enables from a parent.
module timer_pin_edge_filter #(
    parameter int SYNC_STAGES  = 2,
    parameter int FILT_SAMPLES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_async,
    input  logic       tmr_en,
    input  logic       clk_role,
    input  logic       half_tick,
    input  logic       cnt_tick,
    input  logic [1:0] edge_sel,
    output logic       rise_evt,
    output logic       fall_evt,
    output logic       valid_evt
);

    import tpef_pkg::*;

    logic      pin_sync;
    logic      tick_sel;
    logic      lvl_filt;
    edge_sel_e sel_e;

    // Cast the raw select bits to the shared enum.
    always_comb begin
        sel_e = edge_sel_e'(edge_sel);
    end

    tpef_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pin_async),
        .q_sync  (pin_sync)
    );

    tpef_filter #(.SAMPLES(FILT_SAMPLES)) u_filt (
        .clk       (clk),
        .rst_n     (rst_n),
        .lvl_in    (pin_sync),
        .clk_role  (clk_role),
        .half_tick (half_tick),
        .cnt_tick  (cnt_tick),
        .tick_sel  (tick_sel),
        .lvl_out   (lvl_filt)
    );

    tpef_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .lvl       (lvl_filt),
        .tmr_en    (tmr_en),
        .sel       (sel_e),
        .rise_evt  (rise_evt),
        .fall_evt  (fall_evt),
        .valid_evt (valid_evt)
    );

endmodule

// File: rtl/timer_pin_edge_filter_chk.sv
// Module: timer_pin_edge_filter_chk
// Property checker bound to the top; observes ports and the filter level.
// Assumes: synchronous active-low reset.
module timer_pin_edge_filter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tmr_en,
    input logic [1:0] edge_sel,
    input logic       tick_sel,
    input logic       lvl_filt,
    input logic       rise_evt,
    input logic       fall_evt,
    input logic       valid_evt
);

    assert_one_cycle_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rise_evt |=> !rise_evt);

    assert_one_cycle_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fall_evt |=> !fall_evt);

    assert_no_dual_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_evt && fall_evt));

    assert_evt_needs_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_evt || fall_evt || valid_evt) |-> $past(tmr_en));

    assert_none_sel_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        valid_evt |-> ($past(edge_sel) != 2'b11));

    assert_valid_has_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        valid_evt |-> (rise_evt || fall_evt));

    assert_level_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lvl_filt) |-> $past(tick_sel));

endmodule

bind timer_pin_edge_filter timer_pin_edge_filter_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tmr_en    (tmr_en),
    .edge_sel  (edge_sel),
    .tick_sel  (tick_sel),
    .lvl_filt  (lvl_filt),
    .rise_evt  (rise_evt),
    .fall_evt  (fall_evt),
    .valid_evt (valid_evt)
);

// File: tb/tb_timer_pin_edge_filter.sv
// Directed bench for timer_pin_edge_filter.
module tb_timer_pin_edge_filter;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_DIV    = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin_async = 1'b0;
    logic       tmr_en = 1'b0;
    logic       clk_role = 1'b1;
    logic       half_tick = 1'b0;
    logic       cnt_tick = 1'b0;
    logic [1:0] edge_sel = 2'b00;
    logic       rise_evt, fall_evt, valid_evt;

    int n_checks = 0;
    int n_fail   = 0;
    int c_rise = 0, c_fall = 0, c_valid = 0;
    int div_cnt = 0;

    timer_pin_edge_filter dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (pin_async),
        .tmr_en    (tmr_en),
        .clk_role  (clk_role),
        .half_tick (half_tick),
        .cnt_tick  (cnt_tick),
        .edge_sel  (edge_sel),
        .rise_evt  (rise_evt),
        .fall_evt  (fall_evt),
        .valid_evt (valid_evt)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Sampling enables as a parent block would supply them.
    always @(negedge clk) begin
        half_tick <= ~half_tick;
        div_cnt   <= (div_cnt == CNT_DIV-1) ? 0 : div_cnt + 1;
        cnt_tick  <= (div_cnt == CNT_DIV-1);
    end

    // Count output high cycles away from the active edge.
    always @(negedge clk) begin
        if (rise_evt)  c_rise++;
        if (fall_evt)  c_fall++;
        if (valid_evt) c_valid++;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_counts();
        @(posedge clk); #1;
        c_rise = 0; c_fall = 0; c_valid = 0;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input int width);
        @(negedge clk); pin_async = 1'b1;
        cycles(width);
        pin_async = 1'b0;
    endtask

    task automatic do_reset(input bit pin_level);
        @(negedge clk);
        rst_n = 1'b0; tmr_en = 1'b0; pin_async = pin_level;
        cycles(4);
        rst_n = 1'b1;
    endtask

    // R1: outputs idle in and just after reset.
    task automatic t_reset();
        do_reset(1'b0);
        check(!rise_evt && !fall_evt && !valid_evt, "R1 reset idle",
              {rise_evt, fall_evt, valid_evt}, 0);
        @(negedge clk);
        check(!rise_evt && !fall_evt && !valid_evt, "R1 after release",
              {rise_evt, fall_evt, valid_evt}, 0);
    endtask

    // R6 / R8: pin high from reset, first enable reports a rise.
    task automatic t_first_enable();
        do_reset(1'b1);
        clk_role = 1'b1; edge_sel = 2'b00;
        clear_counts();
        cycles(20);
        check(c_rise == 0 && c_valid == 0, "R8 no event while disabled", c_rise, 0);
        @(negedge clk); tmr_en = 1'b1;
        @(negedge clk);
        check(rise_evt == 1'b1, "R6 rise on first enable", rise_evt, 1);
        check(valid_evt == 1'b1, "R6 valid with rising select", valid_evt, 1);
        @(negedge clk);
        check(rise_evt == 1'b0, "R9 rise one cycle", rise_evt, 0);
    endtask

    // R7: stop, change pin while stopped, re-enable silently.
    task automatic t_reenable();
        edge_sel = 2'b10;
        @(negedge clk); tmr_en = 1'b0;
        pin_async = 1'b0;
        cycles(20);
        clear_counts();
        @(negedge clk); tmr_en = 1'b1;
        cycles(10);
        check(c_rise == 0 && c_fall == 0 && c_valid == 0, "R7 silent re-enable",
              c_rise + c_fall + c_valid, 0);
    endtask

    // R2 / R3 / R9: clock role on the half-rate tick.
    task automatic t_clock_role();
        do_reset(1'b0);
        clk_role = 1'b1; edge_sel = 2'b10;
        @(negedge clk); tmr_en = 1'b1;
        cycles(10);
        clear_counts();
        pulse(4);
        cycles(15);
        check(c_rise == 1, "R2 four-cycle pulse rise", c_rise, 1);
        check(c_fall == 1, "R2 four-cycle pulse fall", c_fall, 1);
        check(c_valid == 2, "R9 both-edge valid count", c_valid, 2);
        clear_counts();
        pulse(2);
        cycles(15);
        check(c_rise == 0 && c_fall == 0, "R3 two-cycle glitch dropped", c_rise, 0);
    endtask

    // R4 / R3: capture role on the count tick.
    task automatic t_capture_role();
        clk_role = 1'b0; edge_sel = 2'b10;
        cycles(10);
        clear_counts();
        pulse(4);
        cycles(20);
        check(c_rise == 0 && c_fall == 0, "R4 one-tick pulse dropped", c_rise, 0);
        clear_counts();
        pulse(12);
        cycles(20);
        check(c_rise == 1 && c_fall == 1, "R4 long pulse accepted", c_rise + c_fall, 2);
    endtask

    // R5: each select value on a full pulse.
    task automatic t_select();
        clk_role = 1'b1;
        for (int s = 0; s < 4; s++) begin
            edge_sel = s[1:0];
            cycles(6);
            clear_counts();
            pulse(6);
            cycles(15);
            check(c_rise == 1 && c_fall == 1, "R5 raw edges unaffected",
                  c_rise + c_fall, 2);
            check(c_valid == ((s == 2) ? 2 : (s == 3) ? 0 : 1), "R5 valid by select",
                  c_valid, (s == 2) ? 2 : (s == 3) ? 0 : 1);
        end
    endtask

    // R8: accepted edges while stopped give no events.
    task automatic t_disabled();
        edge_sel = 2'b10;
        @(negedge clk); tmr_en = 1'b0;
        clear_counts();
        pulse(8);
        cycles(15);
        check(c_rise == 0 && c_fall == 0 && c_valid == 0, "R8 stopped timer silent",
              c_rise + c_fall + c_valid, 0);
    endtask

    initial begin
        t_reset();
        t_first_enable();
        t_reenable();
        t_clock_role();
        t_capture_role();
        t_select();
        t_disabled();
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule